// File: doc/BRIEF.md
# Demand-Driven Crossroads Signal Arbiter

This block drives the lamps of a two-road junction with light traffic. Both roads rest at red. A vehicle detector on each road raises an asynchronous request. The request is brought into the clock domain, latched, and granted by a registered arbiter that can give green to only one road at a time. Requests that land in the same clock cycle are settled by a priority bit that flips after every grant, so neither road can starve the other.

A granted road holds green for a set number of cycles. It then shows amber, and an all-red clearance follows before either road can be served again. A request from the crossing road that arrives during a green phase is held and served after the clearance. When no request is held, the junction returns to all-red and waits. Each lamp bus is registered and one-hot.

Top module: `xroad_arbiter`

## Requirements
- R1: A synchronous reset drives both lamp buses to red, discards every held request and gives road A the tie priority. After reset the junction stays red until a new detect arrives.
- R2: While idle, both roads show red. A detect that is high at one rising edge shows as green on the fourth rising edge after it, counting that edge as the first. The path is two synchronizer stages, the request latch and the lamp register.
- R3: A request from one road alone grants green to that road.
- R4: Requests from both roads seen in the same cycle yield exactly one grant. The road holding priority wins, and priority passes to the other road after every grant. The road that loses keeps its request and is served next.
- R5: Each lamp bus is one-hot, with bit 0 red, bit 1 amber and bit 2 green. The two green bits are never high together.
- R6: A green phase lasts exactly GREEN_MIN cycles and is followed by AMBER_LEN cycles of amber. Then come at least CLEAR_LEN+1 cycles with both roads red before any green.
- R7: A request from the crossing road during a green phase is latched, even if the detect pulse lasts one cycle. It is served after the clearance.
- R8: A request from the road that is currently green, arriving during its green, is dropped and causes no further grant.
- R9: After clearance with no request held, the junction returns to all-red and grants nothing.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| det_a_i | input | 1 | Asynchronous vehicle detect, road A |
| det_b_i | input | 1 | Asynchronous vehicle detect, road B |
| lamp_a_o | output | 3 | Road A lamps, one-hot {green, amber, red} |
| lamp_b_o | output | 3 | Road B lamps, one-hot {green, amber, red} |

## Verification
The bench fires detects on both roads in the same cycle, twice, with the priority bit in opposite states. An arbiter with fixed priority, or one that lets both requests through, would show the wrong grant order or two greens at once. It pulses the crossing road during a green and expects a later grant. A design that drops held requests would then leave that road red forever. It also re-triggers the green road during its own green and expects no extra grant, which catches a latch that does not mask the served road. Finally it resets in the middle of a phase while a request is held and checks that the junction stays red and that tie priority is back at road A.

// File: rtl/xr_pkg.sv
package xr_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_GREEN = 2'd1,
        PH_AMBER = 2'd2,
        PH_CLEAR = 2'd3
    } phase_e;

    localparam logic [2:0] LAMP_RED   = 3'b001;
    localparam logic [2:0] LAMP_AMBER = 3'b010;
    localparam logic [2:0] LAMP_GREEN = 3'b100;

    function automatic logic [2:0] lamp_for(phase_e ph, logic mine);
        logic [2:0] l;
        l = LAMP_RED;
        if (mine) begin
            if (ph == PH_GREEN)      l = LAMP_GREEN;
            else if (ph == PH_AMBER) l = LAMP_AMBER;
        end
        return l;
    endfunction
endpackage

// File: rtl/xr_sync.sv
module xr_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/xr_pick.sv
module xr_pick (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] req,
    input  logic [1:0] block,
    input  logic       take,
    output logic       any,
    output logic       win
);
    typedef struct packed {
        logic [1:0] pend;
        logic       prio;
    } pick_t;

    pick_t st_d, st_q;

    always_comb begin
        any  = |st_q.pend;
        win  = (st_q.pend[0] && st_q.pend[1]) ? st_q.prio : st_q.pend[1];
        st_d = st_q;
        st_d.pend = st_q.pend | (req & ~block);
        if (take) begin
            st_d.pend[win] = 1'b0;
            st_d.prio      = ~win;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/xr_timer.sv
module xr_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         done
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)              cnt_d = val;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/xroad_arbiter.sv
module xroad_arbiter #(
    parameter int SYNC_STAGES = 2,
    parameter int GREEN_MIN   = 8,
    parameter int AMBER_LEN   = 4,
    parameter int CLEAR_LEN   = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       det_a_i,
    input  logic       det_b_i,
    output logic [2:0] lamp_a_o,
    output logic [2:0] lamp_b_o
);
    import xr_pkg::*;

    localparam int MAX_LEN = (GREEN_MIN > AMBER_LEN)
                           ? ((GREEN_MIN > CLEAR_LEN) ? GREEN_MIN : CLEAR_LEN)
                           : ((AMBER_LEN > CLEAR_LEN) ? AMBER_LEN : CLEAR_LEN);
    localparam int CNT_W = $clog2(MAX_LEN + 1);

    typedef struct packed {
        phase_e     phase;
        logic       road;
        logic [2:0] lamp_a;
        logic [2:0] lamp_b;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic [1:0]       req_sync;
    logic [1:0]       block;
    logic             take, any, win;
    logic             load, done;
    logic [CNT_W-1:0] load_val;

    xr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din({det_b_i, det_a_i}), .dout(req_sync)
    );

    xr_pick u_pick (
        .clk(clk), .rst(rst), .req(req_sync), .block(block),
        .take(take), .any(any), .win(win)
    );

    xr_timer #(.W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(load), .val(load_val), .done(done)
    );

    always_comb begin
        ctl_d    = ctl_q;
        take     = 1'b0;
        load     = 1'b0;
        load_val = '0;
        block    = (ctl_q.phase == PH_GREEN) ? {ctl_q.road, ~ctl_q.road} : 2'b00;
        case (ctl_q.phase)
            PH_IDLE: if (any) begin
                take        = 1'b1;
                load        = 1'b1;
                load_val    = CNT_W'(GREEN_MIN - 1);
                ctl_d.phase = PH_GREEN;
                ctl_d.road  = win;
            end
            PH_GREEN: if (done) begin
                load        = 1'b1;
                load_val    = CNT_W'(AMBER_LEN - 1);
                ctl_d.phase = PH_AMBER;
            end
            PH_AMBER: if (done) begin
                load        = 1'b1;
                load_val    = CNT_W'(CLEAR_LEN - 1);
                ctl_d.phase = PH_CLEAR;
            end
            default: if (done) begin
                ctl_d.phase = PH_IDLE;
            end
        endcase
        ctl_d.lamp_a = lamp_for(ctl_d.phase, ctl_d.road == 1'b0);
        ctl_d.lamp_b = lamp_for(ctl_d.phase, ctl_d.road == 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.phase  <= PH_IDLE;
            ctl_q.road   <= 1'b0;
            ctl_q.lamp_a <= LAMP_RED;
            ctl_q.lamp_b <= LAMP_RED;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign lamp_a_o = ctl_q.lamp_a;
    assign lamp_b_o = ctl_q.lamp_b;
endmodule

// File: rtl/xr_chk.sv
module xr_chk #(
    parameter int GREEN_MIN = 8
) (
    input logic       clk,
    input logic       rst,
    input logic [2:0] lamp_a,
    input logic [2:0] lamp_b
);
    localparam int GW = $clog2(GREEN_MIN + 2);

    logic [GW-1:0] gcnt_q;
    logic          g_a, g_b;

    assign g_a = lamp_a[2];
    assign g_b = lamp_b[2];

    always_ff @(posedge clk) begin
        if (rst)                                    gcnt_q <= '0;
        else if ((g_a || g_b) && gcnt_q != '1)      gcnt_q <= gcnt_q + 1'b1;
        else if (!(g_a || g_b))                     gcnt_q <= '0;
    end

    // R5
    both_green_chk: assert property (@(posedge clk) disable iff (rst)
        !(g_a && g_b));

    // R5
    lamp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(lamp_a) == 1) && ($countones(lamp_b) == 1));

    // R6
    green_from_red_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(g_a) || $rose(g_b)) |-> $past(lamp_a == 3'b001 && lamp_b == 3'b001));

    // R6
    green_to_amber_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(g_a)) |-> (lamp_a == 3'b010));

    // R6
    min_green_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !(g_a || g_b) && $past(g_a || g_b)) |-> (gcnt_q == GW'(GREEN_MIN)));
endmodule

bind xroad_arbiter xr_chk #(.GREEN_MIN(GREEN_MIN)) u_chk (
    .clk(clk), .rst(rst), .lamp_a(lamp_a_o), .lamp_b(lamp_b_o)
);

// File: tb/tb_xroad_arbiter.sv
module tb_xroad_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int G = 8;
    localparam int A = 4;
    localparam int C = 3;
    localparam logic [2:0] RED = 3'b001, AMB = 3'b010, GRN = 3'b100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic det_a = 1'b0, det_b = 1'b0;
    logic [2:0] lamp_a, lamp_b;

    int checks = 0;
    int errors = 0;
    logic exp_q[$];

    xroad_arbiter #(.SYNC_STAGES(2), .GREEN_MIN(G), .AMBER_LEN(A), .CLEAR_LEN(C)) dut (
        .clk(clk), .rst(rst), .det_a_i(det_a), .det_b_i(det_b),
        .lamp_a_o(lamp_a), .lamp_b_o(lamp_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse(input bit a, input bit b);
        @(negedge clk);
        det_a = a;
        det_b = b;
        @(negedge clk);
        det_a = 1'b0;
        det_b = 1'b0;
    endtask

    // monitor: pops expected grants, checks phase lengths
    logic prev_ga = 1'b0, prev_gb = 1'b0, prev_am = 1'b0;
    int glen = 0, alen = 0, redrun = 100;

    always @(negedge clk) begin
        logic ga, gb, am, rise, r;
        if (rst) begin
            prev_ga = 1'b0; prev_gb = 1'b0; prev_am = 1'b0;
            glen = 0; alen = 0; redrun = 100;
        end else begin
            ga = (lamp_a == GRN);
            gb = (lamp_b == GRN);
            am = (lamp_a == AMB) || (lamp_b == AMB);
            chk(!(ga && gb), "R5", "both green", 1, 0);
            rise = (ga && !prev_ga) || (gb && !prev_gb);
            if (rise) begin
                r = gb;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected green on road", int'(r), -1);
                end else begin
                    logic e;
                    e = exp_q.pop_front();
                    chk(r == e, "R4", "granted road (R3/R7 order)", int'(r), int'(e));
                end
                chk(redrun >= C + 1, "R6", "all-red before green", redrun, C + 1);
            end
            if (ga || gb) glen++;
            else if (prev_ga || prev_gb) begin
                chk(glen == G, "R6", "green length", glen, G);
                chk(am, "R6", "amber after green", int'(am), 1);
                glen = 0;
            end
            if (am) alen++;
            else if (prev_am) begin
                chk(alen == A, "R6", "amber length", alen, A);
                alen = 0;
            end
            if (lamp_a == RED && lamp_b == RED) redrun++;
            else redrun = 0;
            prev_ga = ga; prev_gb = gb; prev_am = am;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(lamp_a == RED && lamp_b == RED, "R1", "lamps in reset", {lamp_a, lamp_b}, {RED, RED});
        rst = 1'b0;
        repeat (20) @(negedge clk);
        chk(lamp_a == RED && lamp_b == RED, "R2", "idle all red", {lamp_a, lamp_b}, {RED, RED});

        // R2 latency, R3 single request on A
        exp_q.push_back(1'b0);
        @(negedge clk); det_a = 1'b1;
        @(negedge clk); det_a = 1'b0;
        repeat (2) @(negedge clk);
        chk(lamp_a == RED, "R2", "red after 3 edges", lamp_a, RED);
        @(negedge clk);
        chk(lamp_a == GRN, "R2", "green on 4th edge", lamp_a, GRN);
        repeat (30) @(negedge clk);

        // R3 single request on B
        exp_q.push_back(1'b1);
        pulse(1'b0, 1'b1);
        repeat (30) @(negedge clk);

        // R4 tie: priority at A after B's grant
        exp_q.push_back(1'b0); exp_q.push_back(1'b1);
        pulse(1'b1, 1'b1);
        repeat (55) @(negedge clk);

        // A alone, priority moves to B
        exp_q.push_back(1'b0);
        pulse(1'b1, 1'b0);
        repeat (30) @(negedge clk);

        // R4 tie: B wins this time
        exp_q.push_back(1'b1); exp_q.push_back(1'b0);
        pulse(1'b1, 1'b1);
        repeat (55) @(negedge clk);

        // R8 re-trigger of green road is dropped, R9 idle after
        exp_q.push_back(1'b0);
        pulse(1'b1, 1'b0);
        repeat (5) @(negedge clk);
        pulse(1'b1, 1'b0);
        repeat (40) @(negedge clk);
        chk(exp_q.size() == 0, "R8", "grants outstanding", exp_q.size(), 0);
        chk(lamp_a == RED && lamp_b == RED, "R9", "back to idle red", {lamp_a, lamp_b}, {RED, RED});

        // R7 crossing request during green served after clearance
        exp_q.push_back(1'b0); exp_q.push_back(1'b1);
        pulse(1'b1, 1'b0);
        repeat (5) @(negedge clk);
        pulse(1'b0, 1'b1);
        repeat (55) @(negedge clk);
        chk(exp_q.size() == 0, "R7", "latched request served", exp_q.size(), 0);

        // R1 reset in mid-green with B held
        exp_q.push_back(1'b0);
        pulse(1'b1, 1'b0);
        repeat (5) @(negedge clk);
        pulse(1'b0, 1'b1);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk(lamp_a == RED && lamp_b == RED, "R1", "red after reset", {lamp_a, lamp_b}, {RED, RED});
        repeat (40) @(negedge clk);
        chk(lamp_b == RED, "R1", "held request cleared", lamp_b, RED);

        // R1 priority back at A after reset
        exp_q.push_back(1'b0); exp_q.push_back(1'b1);
        pulse(1'b1, 1'b1);
        repeat (55) @(negedge clk);
        chk(exp_q.size() == 0, "R9", "grants outstanding at end", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule